// File: doc/BRIEF.md
# Three-Channel Down-Counter Bank with Wide Time-Stamp

This block gives a processor three down-counting timer channels and one 40-bit up-counter for time stamps. All of them sit behind a small register bus with single-cycle writes and registered reads. The rate logic lives outside the block. Each counter advances only on single-cycle enable pulses: a slow reference, a fast reference (nominally 508469 Hz) or a stamp reference (nominally 983040 Hz).

A channel counts down from a loaded value. It takes its steps from whichever reference its control register selects. On each underflow it raises a sticky interrupt. In periodic mode it then reloads, so a load value of N gives one underflow every N+1 reference pulses. In free-running mode it wraps to the all-ones value of its width. The first two channels are 16 bits wide and the third is 32 bits wide.

To start a channel, software first writes control with the run bit clear, then writes the load value, then sets the run bit. The interrupt is cleared by writing any value to the channel's clear address. The time-stamp counter is read as a low word and a high register. The high register holds the top byte and the enable bit.

Top module: `tick_timer_bank`

## Requirements
- R1: While `rst` is high, every load, value, control, interrupt and time-stamp register returns to zero, and `bus_rdata` returns to zero.
- R2: Each channel's registers start at a base address of 0x00, 0x20 or 0x80. Within that group, load is at +0x0, value at +0x4, control at +0x8 and clear at +0xC. `bus_rdata` shows the register addressed in the previous cycle. Unmapped addresses read zero and ignore writes.
- R3: In the control register, bit 7 is the run bit, bit 6 selects periodic mode and bit 3 selects the fast reference. All other bits read back as zero.
- R4: A load write stores the value in both the load register and the current value, whatever the run bit holds. A channel whose run bit is clear keeps its value across reference pulses.
- R5: A running channel decrements by one on each pulse of its selected reference and ignores pulses on the other reference.
- R6: In periodic mode, a load value of N gives an underflow on every (N+1)-th selected pulse, and the value reloads to N at that pulse.
- R7: In free-running mode, an underflow sets the value to all ones of the channel width: 0xFFFF for channels 0 and 1, 0xFFFFFFFF for channel 2.
- R8: The interrupt of a channel rises on its underflow pulse and stays high until a write of any data to that channel's clear address. If a clear write and an underflow fall in the same cycle, the interrupt ends low.
- R9: A load write in the same cycle as a counting pulse wins. The value takes the written data and no underflow is recorded.
- R10: The time-stamp counter increments on each `tick_stamp` pulse while enabled. Bit 8 of the register at 0x64 is the enable. Address 0x60 reads counter bits 31:0, and 0x64 reads bits 39:32 in bits 7:0 with the enable in bit 8.
- R11: Writing 0x64 with bit 8 clear zeroes the time-stamp counter, and it stays at zero while disabled.
- R12: On 16-bit channels, a write to load keeps only bits 15:0. Reads of a channel return its registers zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Slow reference enable pulse |
| tick_fast | input | 1 | Fast reference enable pulse |
| tick_stamp | input | 1 | Time-stamp reference enable pulse |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq | output | 3 | Sticky interrupt level, one per channel |

## Verification
Two pairs of events can land in the same clock cycle, and each pair is tested directly.

The first pair is an underflow and a clear write. The bench parks a free-running channel at zero, then drives a reference pulse and a clear write together. It expects the interrupt to end low, with the value still wrapped to all ones.

The second pair is a counting pulse and a load write. The bench drives them together on a channel sitting at zero. It expects the written value, with no interrupt raised.

A per-cycle property also checks that no clear write is ever followed by a high interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH        = 3;
  localparam int OFF_LOAD   = 'h0;
  localparam int OFF_VALUE  = 'h4;
  localparam int OFF_CTRL   = 'h8;
  localparam int OFF_CLR    = 'hC;
  localparam int STAMP_LO   = 'h60;
  localparam int STAMP_HI   = 'h64;
  localparam int BIT_RUN    = 7;
  localparam int BIT_PER    = 6;
  localparam int BIT_FAST   = 3;
  localparam int BIT_ST_EN  = 8;

  function automatic int chan_base(int i);
    case (i)
      0:       return 'h00;
      1:       return 'h20;
      default: return 'h80;
    endcase
  endfunction

  function automatic int chan_width(int i);
    return (i == NCH - 1) ? 32 : 16;
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W      = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [W-1:0]      value,
  output logic [W-1:0]      load_q,
  output logic              run,
  output logic              periodic,
  output logic              fast_sel,
  output logic              irq
);
  logic step;
  logic uf;
  logic unused_wd;

  assign unused_wd = ^wdata;
  assign step      = run && (fast_sel ? tick_fast : tick_slow);
  // a load write in the same cycle suppresses the underflow
  assign uf        = step && (value == '0) && !wr_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      value    <= '0;
      load_q   <= '0;
      run      <= 1'b0;
      periodic <= 1'b0;
      fast_sel <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run      <= wdata[BIT_RUN];
        periodic <= wdata[BIT_PER];
        fast_sel <= wdata[BIT_FAST];
      end
      if (wr_load) begin
        load_q <= wdata[W-1:0];
        value  <= wdata[W-1:0];
      end else if (step) begin
        if (value == '0) value <= periodic ? load_q : '1;
        else             value <= value - 1'b1;
      end
      if (wr_clr)  irq <= 1'b0;
      else if (uf) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_stamp.sv
module tmr_stamp #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_ctl,
  input  logic         en_in,
  output logic [W-1:0] cnt,
  output logic         en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      en  <= 1'b0;
    end else begin
      if (wr_ctl) en <= en_in;
      if (wr_ctl && !en_in)  cnt <= '0;
      else if (en && tick)   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              tick_stamp,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq
);
  logic [NCH-1:0][DATA_W-1:0] ch_val;
  logic [NCH-1:0][DATA_W-1:0] ch_load;
  logic [NCH-1:0][DATA_W-1:0] ch_ctrl;
  logic [NCH-1:0]             ch_en;
  logic [STAMP_W-1:0]         stamp_cnt;
  logic                       stamp_en;
  logic [DATA_W-1:0]          rd_next;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int CW = chan_width(i);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(chan_base(i) + OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(chan_base(i) + OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(chan_base(i) + OFF_CLR);
    logic [CW-1:0] val;
    logic [CW-1:0] ld;
    logic          per;
    logic          fsel;

    tmr_channel #(.W(CW), .DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .tick_slow(tick_slow),
      .tick_fast(tick_fast),
      .wr_load  (bus_wr && bus_addr == A_LOAD),
      .wr_ctrl  (bus_wr && bus_addr == A_CTRL),
      .wr_clr   (bus_wr && bus_addr == A_CLR),
      .wdata    (bus_wdata),
      .value    (val),
      .load_q   (ld),
      .run      (ch_en[i]),
      .periodic (per),
      .fast_sel (fsel),
      .irq      (irq[i])
    );

    assign ch_val[i]  = DATA_W'(val);
    assign ch_load[i] = DATA_W'(ld);
    // readback layout: run bit 7, periodic bit 6, fast select bit 3
    assign ch_ctrl[i] = DATA_W'({ch_en[i], per, 2'b00, fsel, 3'b000});
  end

  tmr_stamp #(.W(STAMP_W)) u_stamp (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_stamp),
    .wr_ctl(bus_wr && bus_addr == ADDR_W'(STAMP_HI)),
    .en_in (bus_wdata[BIT_ST_EN]),
    .cnt   (stamp_cnt),
    .en    (stamp_en)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADDR_W'(chan_base(i) + OFF_LOAD))  rd_next = ch_load[i];
      if (bus_addr == ADDR_W'(chan_base(i) + OFF_VALUE)) rd_next = ch_val[i];
      if (bus_addr == ADDR_W'(chan_base(i) + OFF_CTRL))  rd_next = ch_ctrl[i];
    end
    if (bus_addr == ADDR_W'(STAMP_LO)) rd_next = stamp_cnt[DATA_W-1:0];
    if (bus_addr == ADDR_W'(STAMP_HI)) rd_next = DATA_W'({stamp_en, stamp_cnt[STAMP_W-1:DATA_W]});
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk
  import tmr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 40
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick_stamp,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [NCH-1:0]             irq,
  input logic [NCH-1:0][DATA_W-1:0] ch_val,
  input logic [NCH-1:0]             ch_en,
  input logic [STAMP_W-1:0]         stamp_cnt,
  input logic                       stamp_en
);
  logic hi_wr;
  assign hi_wr = bus_wr && bus_addr == ADDR_W'(STAMP_HI);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq == '0 && stamp_cnt == '0));

  a_r11_stamp_zero: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !bus_wdata[BIT_ST_EN]) |=> stamp_cnt == '0);

  a_r10_stamp_step: assert property (@(posedge clk) disable iff (rst)
    (stamp_en && tick_stamp && !hi_wr) |=> stamp_cnt == $past(stamp_cnt) + 1'b1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(chan_base(i) + OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(chan_base(i) + OFF_CLR);

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_CLR) |=> !irq[i]);

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      (irq[i] && !(bus_wr && bus_addr == A_CLR)) |=> irq[i]);

    a_r8_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[i]) |-> $past(ch_en[i]));

    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (rst)
      (!ch_en[i] && !(bus_wr && bus_addr == A_LOAD)) |=> $stable(ch_val[i]));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAMP_W(STAMP_W)
) u_chk (.*);

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        tick_stamp = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tick_timer_bank uut (
    .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .tick_stamp(tick_stamp), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [7:0] base(int ch);
    return (ch == 0) ? 8'h00 : (ch == 1) ? 8'h20 : 8'h80;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // 0 slow, 1 fast, 2 stamp
  task automatic pulse(int which, bit with_wr, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    if (which == 0) tick_slow = 1'b1;
    else if (which == 1) tick_fast = 1'b1;
    else tick_stamp = 1'b1;
    if (with_wr) begin bus_addr = a; bus_wdata = d; bus_wr = 1'b1; end
    @(negedge clk);
    tick_slow = 1'b0; tick_fast = 1'b0; tick_stamp = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 map
    chk("R1", "irq after reset", {29'b0, irq}, 32'h0);
    for (int c = 0; c < 3; c++)
      for (int o = 0; o < 12; o += 4) begin
        rd(base(c) + 8'(o), d);
        chk("R1", "channel reg after reset", d, 32'h0);
      end
    rd(8'h60, d); chk("R1", "stamp low after reset", d, 0);
    rd(8'h64, d); chk("R1", "stamp high after reset", d, 0);

    // R2 unmapped address
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, d); chk("R2", "unmapped read", d, 0);
    rd(8'h20, d); chk("R2", "ch1 load untouched by unmapped write", d, 0);

    // R3 control bits
    wr(base(1) + 8'h8, 32'hFFFF_FFFF);
    rd(base(1) + 8'h8, d); chk("R3", "ctrl readback", d, 32'hC8);
    wr(base(1) + 8'h8, 32'h0);
    rd(base(1) + 8'h8, d); chk("R3", "ctrl cleared", d, 32'h0);

    // R12 width handling
    wr(base(0), 32'h0001_2345);
    rd(base(0), d); chk("R12", "ch0 load truncated", d, 32'h2345);
    rd(base(0) + 8'h4, d); chk("R12", "ch0 value truncated", d, 32'h2345);
    wr(base(2), 32'h0ABC_DE12);
    rd(base(2), d); chk("R12", "ch2 load full", d, 32'h0ABC_DE12);

    // R4 load while off does not count
    wr(base(0), 32'd5);
    for (int k = 0; k < 3; k++) pulse(0, 0, 0, 0);
    rd(base(0) + 8'h4, d); chk("R4", "ch0 holds while off", d, 5);

    // R5 only the selected reference counts
    wr(base(0) + 8'h8, 32'hC0);
    pulse(1, 0, 0, 0); pulse(1, 0, 0, 0);
    rd(base(0) + 8'h4, d); chk("R5", "fast pulses ignored on slow select", d, 5);
    pulse(0, 0, 0, 0);
    rd(base(0) + 8'h4, d); chk("R5", "slow pulse decrements", d, 4);
    wr(base(0) + 8'h8, 32'h0);

    // R6 periodic sweep
    for (int c = 0; c < 3; c++)
      for (int n = 0; n < 5; n++) begin
        int f;
        f = n % 2;
        wr(base(c) + 8'h8, 32'h40 | (f != 0 ? 32'h8 : 32'h0));
        wr(base(c), 32'(n));
        wr(base(c) + 8'hC, 32'h1);
        wr(base(c) + 8'h8, 32'hC0 | (f != 0 ? 32'h8 : 32'h0));
        for (int k = 1; k <= 2 * (n + 1); k++) begin
          pulse(f, 0, 0, 0);
          rd(base(c) + 8'h4, d);
          chk("R6", "periodic value", d, 32'(n - (k % (n + 1))));
          chk("R6", "periodic irq", {31'b0, irq[c]}, {31'b0, k >= n + 1});
        end
        wr(base(c) + 8'h8, 32'h0);
        wr(base(c) + 8'hC, 32'h0);
      end

    // R7 free-running wrap
    wr(base(0), 32'd1);
    wr(base(0) + 8'h8, 32'h80);
    pulse(0, 0, 0, 0); pulse(0, 0, 0, 0);
    rd(base(0) + 8'h4, d); chk("R7", "ch0 wraps to 16-bit ones", d, 32'hFFFF);
    chk("R7", "ch0 irq on wrap", {31'b0, irq[0]}, 1);
    wr(base(2), 32'd0);
    wr(base(2) + 8'h8, 32'h88);
    pulse(1, 0, 0, 0);
    rd(base(2) + 8'h4, d); chk("R7", "ch2 wraps to 32-bit ones", d, 32'hFFFF_FFFF);
    pulse(1, 0, 0, 0);
    chk("R8", "ch2 irq sticky across pulses", {31'b0, irq[2]}, 1);
    wr(base(2) + 8'hC, 32'h0);
    chk("R8", "ch2 cleared by zero write", {31'b0, irq[2]}, 0);

    // R8 clear with any data, clear beats underflow
    wr(base(0) + 8'hC, 32'hDEAD);
    chk("R8", "ch0 clear", {31'b0, irq[0]}, 0);
    wr(base(0), 32'd0);
    pulse(0, 1, base(0) + 8'hC, 32'h5A5A);
    chk("R8", "clear wins over underflow", {31'b0, irq[0]}, 0);
    rd(base(0) + 8'h4, d); chk("R8", "underflow still wrapped", d, 32'hFFFF);
    wr(base(0) + 8'h8, 32'h0);

    // R9 load beats tick
    wr(base(1) + 8'h8, 32'h40);
    wr(base(1), 32'd0);
    wr(base(1) + 8'hC, 32'h0);
    wr(base(1) + 8'h8, 32'hC0);
    pulse(0, 1, base(1), 32'd9);
    rd(base(1) + 8'h4, d); chk("R9", "load wins value", d, 9);
    chk("R9", "no underflow recorded", {31'b0, irq[1]}, 0);
    pulse(0, 0, 0, 0);
    rd(base(1) + 8'h4, d); chk("R9", "counts on after load", d, 8);
    wr(base(1) + 8'h8, 32'h0);

    // R10 stamp counting
    wr(8'h64, 32'h100);
    for (int k = 0; k < 5; k++) pulse(2, 0, 0, 0);
    pulse(0, 0, 0, 0); pulse(1, 0, 0, 0);
    rd(8'h60, d); chk("R10", "stamp low count", d, 5);
    rd(8'h64, d); chk("R10", "stamp high with enable", d, 32'h100);

    // R11 disable zeroes and holds
    wr(8'h64, 32'h0);
    rd(8'h60, d); chk("R11", "stamp zeroed", d, 0);
    for (int k = 0; k < 3; k++) pulse(2, 0, 0, 0);
    rd(8'h60, d); chk("R11", "stamp held off", d, 0);
    rd(8'h64, d); chk("R11", "stamp high off", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule